// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the synchronous digital controller of a bidirectional, noise-shaped dual-slope integrating converter. A free-running phase counter paces every conversion over a fixed number of clock periods. The first part of each conversion integrates the input. Its end is retimed on the falling clock edge, so the charge interval lasts a half-integer number of periods. The remaining time is used to discharge the integrator against a reference of the opposite sign, and then to sample the result.

The block has two comparator inputs. The first is a polarity comparator that reports which side of midscale the integrator output is on. The second is a half-LSB comparator whose threshold sign follows the captured direction. From these the block drives the charge, discharge and sample phase signals, the reference polarity select, the threshold select and the half-LSB compensation sign. At the end of each conversion it emits a sign-magnitude code and a one-cycle valid pulse. The last discharge is allowed to overshoot zero, and the residue it leaves is carried into the next charge, which gives noise shaping. The half-LSB comparison adds one bit of resolution on top of the short discharge counter.

Top module: `dsadc_seq`

## Requirements
- R1: With the default SEQ_W = 3, each conversion lasts exactly 8 clock periods, and valid_o is high for exactly one cycle at the end of each one.
- R2: charge_o is high from the start of a conversion until the falling edge in its fourth period, so it lasts 3.5 periods.
- R3: At that falling edge the block captures pol_in (1 = integrator above midscale) as the direction. discharge_o then stays high until the first falling edge at which pol_in differs from the captured direction.
- R4: sample_o rises at the falling edge where the mismatch is seen, and stays high until the conversion ends. If no mismatch is seen, it rises at the falling edge in the last period.
- R5: While discharging, ref_neg_o equals the captured direction (1 selects the negative reference). thr_neg_o carries the same value and selects the negative half-LSB threshold.
- R6: comp_pos_o equals pol_in while charge_o is high, and is 0 otherwise. It gives the sign of the half-LSB compensation.
- R7: code_o[3] is the captured direction. code_o[2:1] is the number of rising edges in periods 5, 6 and 7 at which the discharge slope is still active, so the crossing position gives 0, 1, 2 or 3.
- R8: code_o[0] comes from half_in (1 = integrator above the selected threshold), taken at the first rising edge of the sample sub-phase. With direction 0 it is 1 when the integrator is at or below +half-LSB. With direction 1 it is 1 when the integrator is above -half-LSB.
- R9: If no zero crossing is detected, code_o[2:1] saturates at 3.
- R10: A synchronous reset clears the counters, the direction, code_o and valid_o, and the next conversion starts at the first period after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| pol_in | input | 1 | Polarity comparator, 1 = integrator above midscale |
| half_in | input | 1 | Half-LSB comparator, 1 = integrator above selected threshold |
| charge_o | output | 1 | Input integration enable |
| discharge_o | output | 1 | Reference integration enable |
| sample_o | output | 1 | Sample sub-phase strobe |
| ref_neg_o | output | 1 | 1 selects negative reference for discharge |
| thr_neg_o | output | 1 | 1 selects negative half-LSB comparator threshold |
| comp_pos_o | output | 1 | Half-LSB compensation sign during charge, 1 = positive |
| code_o | output | SEQ_W+1 | Sign, doubled count, extra LSB |
| valid_o | output | 1 | One-cycle pulse when code_o is updated |

## Verification
A wrong phase counter or a misbehaving falling-edge retiming flop shows up as a charge or discharge edge that is a half period out of place. It is visible at the phase outputs within the same conversion. A wrong captured direction inverts ref_neg_o during the discharge and the sign bit at the next valid pulse. A discharge counter that drops or adds an edge, or that fails to saturate, changes code_o[2:1] within at most 8 cycles. The bench drives a behavioural integrator whose residue carries across conversions, so the crossing positions vary and errors of this kind are exposed.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
   // width of the output code: sign, count bits, refinement bit
   function automatic int code_w(input int seq_w);
      return seq_w + 1;
   endfunction
   // width of the discharge counter
   function automatic int disch_w(input int seq_w);
      return seq_w - 1;
   endfunction
endpackage

// File: rtl/dsadc_phase.sv
module dsadc_phase #(
   parameter int SEQ_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   output logic [SEQ_W-1:0] cnt_o,
   output logic             charge_o
);
   localparam int CHG_I = (1 << (SEQ_W - 1)) - 1;
   localparam logic [SEQ_W-1:0] CHG_FULL = CHG_I[SEQ_W-1:0];

   logic [SEQ_W-1:0] cnt_q;
   logic             tail_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   // half-period retiming of the charge end
   always_ff @(negedge clk) begin
      if (rst) tail_q <= 1'b0;
      else     tail_q <= (cnt_q == CHG_FULL);
   end

   assign cnt_o    = cnt_q;
   assign charge_o = (cnt_q < CHG_FULL) | ((cnt_q == CHG_FULL) & ~tail_q);
endmodule

// File: rtl/dsadc_zcross.sv
module dsadc_zcross #(
   parameter int SEQ_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEQ_W-1:0] cnt_i,
   input  logic             pol_in,
   output logic             dir_o,
   output logic             samp_o
);
   localparam int CHG_I = (1 << (SEQ_W - 1)) - 1;
   localparam logic [SEQ_W-1:0] CHG_FULL = CHG_I[SEQ_W-1:0];
   localparam logic [SEQ_W-1:0] LAST     = '1;

   logic dir_q;
   logic samp_q;

   always_ff @(negedge clk) begin
      if (rst)                  dir_q <= 1'b0;
      else if (cnt_i == CHG_FULL) dir_q <= pol_in;
   end

   always_ff @(negedge clk) begin
      if (rst)
         samp_q <= 1'b0;
      else if (cnt_i > CHG_FULL)
         samp_q <= samp_q | (pol_in != dir_q) | (cnt_i == LAST);
      else
         samp_q <= 1'b0;
   end

   assign dir_o  = dir_q;
   assign samp_o = samp_q;
endmodule

// File: rtl/dsadc_code.sv
module dsadc_code #(
   parameter int SEQ_W       = 3,
   parameter bit HALF_LSB_EN = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic [SEQ_W-1:0]                    cnt_i,
   input  logic                                samp_i,
   input  logic                                dir_i,
   input  logic                                half_i,
   output logic [dsadc_pkg::code_w(SEQ_W)-1:0] code_o,
   output logic                                valid_o
);
   localparam int CW = dsadc_pkg::code_w(SEQ_W);
   localparam int MW = dsadc_pkg::disch_w(SEQ_W);
   localparam int CHG_I = (1 << (SEQ_W - 1)) - 1;
   localparam logic [SEQ_W-1:0] CHG_FULL = CHG_I[SEQ_W-1:0];
   localparam logic [SEQ_W-1:0] LAST     = '1;

   logic [MW-1:0] dcnt_q;
   logic          lsb_q;
   logic          taken_q;
   logic          lsb_live;
   logic          lsb_now;
   logic [CW-1:0] code_q;
   logic          valid_q;

   generate
      if (HALF_LSB_EN) begin : g_half
         assign lsb_live = ~(half_i ^ dir_i);
      end else begin : g_nohalf
         assign lsb_live = 1'b0;
      end
   endgenerate

   assign lsb_now = taken_q ? lsb_q : lsb_live;

   always_ff @(posedge clk) begin
      if (rst) begin
         dcnt_q  <= '0;
         lsb_q   <= 1'b0;
         taken_q <= 1'b0;
         code_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= (cnt_i == LAST);
         if (cnt_i == LAST) begin
            code_q  <= {dir_i, dcnt_q, lsb_now};
            dcnt_q  <= '0;
            lsb_q   <= 1'b0;
            taken_q <= 1'b0;
         end else if (cnt_i > CHG_FULL) begin
            if (!samp_i && dcnt_q != '1)
               dcnt_q <= dcnt_q + 1'b1;
            if (samp_i && !taken_q) begin
               lsb_q   <= lsb_live;
               taken_q <= 1'b1;
            end
         end
      end
   end

   assign code_o  = code_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
   parameter int SEQ_W       = 3,
   parameter bit HALF_LSB_EN = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                pol_in,
   input  logic                                half_in,
   output logic                                charge_o,
   output logic                                discharge_o,
   output logic                                sample_o,
   output logic                                ref_neg_o,
   output logic                                thr_neg_o,
   output logic                                comp_pos_o,
   output logic [dsadc_pkg::code_w(SEQ_W)-1:0] code_o,
   output logic                                valid_o
);
   localparam int CHG_I = (1 << (SEQ_W - 1)) - 1;
   localparam logic [SEQ_W-1:0] CHG_FULL = CHG_I[SEQ_W-1:0];

   generate
      if (SEQ_W < 2) begin : g_bad_seq_w
         $error("dsadc_seq: SEQ_W must be at least 2");
      end
   endgenerate

   logic [SEQ_W-1:0] cnt;
   logic             charge;
   logic             dir;
   logic             samp;

   dsadc_phase #(.SEQ_W(SEQ_W)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .cnt_o    (cnt),
      .charge_o (charge)
   );

   dsadc_zcross #(.SEQ_W(SEQ_W)) u_zcross (
      .clk    (clk),
      .rst    (rst),
      .cnt_i  (cnt),
      .pol_in (pol_in),
      .dir_o  (dir),
      .samp_o (samp)
   );

   dsadc_code #(.SEQ_W(SEQ_W), .HALF_LSB_EN(HALF_LSB_EN)) u_code (
      .clk     (clk),
      .rst     (rst),
      .cnt_i   (cnt),
      .samp_i  (samp),
      .dir_i   (dir),
      .half_i  (half_in),
      .code_o  (code_o),
      .valid_o (valid_o)
   );

   assign charge_o    = charge;
   assign discharge_o = (cnt >= CHG_FULL) & ~charge & ~samp;
   assign sample_o    = samp & (cnt > CHG_FULL);
   assign ref_neg_o   = dir;
   assign thr_neg_o   = dir;
   assign comp_pos_o  = charge & pol_in;
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
   parameter int SEQ_W = 3
) (
   input logic clk,
   input logic rst,
   input logic charge_o,
   input logic discharge_o,
   input logic sample_o,
   input logic ref_neg_o,
   input logic valid_o
);
   localparam int LEN = 1 << SEQ_W;

   logic [7:0] gap_q;
   logic       seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (valid_o) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != 8'hFF) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   a_r1_valid_single: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   a_r1_valid_period: assert property (@(posedge clk) disable iff (rst)
      (valid_o && seen_q) |-> (int'(gap_q) == LEN - 1));

   a_r2_charge_alone: assert property (@(posedge clk) disable iff (rst)
      !(charge_o && (discharge_o || sample_o)));

   a_r3_discharge_follows: assert property (@(posedge clk) disable iff (rst)
      $fell(charge_o) |-> discharge_o);

   a_r4_slope_or_sample: assert property (@(posedge clk) disable iff (rst)
      !(discharge_o && sample_o));

   a_r4_sample_before_valid: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> $past(sample_o));

   a_r5_ref_steady: assert property (@(posedge clk) disable iff (rst)
      (discharge_o && $past(discharge_o)) |-> $stable(ref_neg_o));
endmodule

bind dsadc_seq dsadc_seq_chk #(.SEQ_W(SEQ_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .charge_o    (charge_o),
   .discharge_o (discharge_o),
   .sample_o    (sample_o),
   .ref_neg_o   (ref_neg_o),
   .valid_o     (valid_o)
);

// File: tb/tb_dsadc_seq.sv
`timescale 1ns/1ps
module tb_dsadc_seq;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pol_in = 1'b0;
   logic half_in = 1'b0;
   logic charge_o, discharge_o, sample_o, ref_neg_o, thr_neg_o, comp_pos_o;
   logic [3:0] code_o;
   logic valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int resid = 0;

   always #2.5 clk = ~clk;

   dsadc_seq dut (
      .clk(clk), .rst(rst), .pol_in(pol_in), .half_in(half_in),
      .charge_o(charge_o), .discharge_o(discharge_o), .sample_o(sample_o),
      .ref_neg_o(ref_neg_o), .thr_neg_o(thr_neg_o), .comp_pos_o(comp_pos_o),
      .code_o(code_o), .valid_o(valid_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one conversion; entered 1 ns after the rising edge that starts period 0
   task automatic run_conv(input int a);
      int x, xj, xr, jc;
      bit d, det, idle_ok;
      logic [3:0] exp_code;
      int exp_cnt;
      bit exp_lsb;
      x = resid + a;
      d = (x > 0);
      jc = 0;
      xr = d ? x - 16 : x + 16;
      for (int j = 1; j <= 4; j++) begin
         xj = d ? x - 4 * j : x + 4 * j;
         if (jc == 0 && ((xj > 0) != d)) begin
            jc = j;
            xr = xj;
         end
      end
      exp_cnt = (jc == 0) ? 3 : jc - 1;
      exp_lsb = d ? (xr > -2) : (xr <= 2);
      exp_code = {d, exp_cnt[1:0], exp_lsb};
      idle_ok = 1'b1;
      for (int c = 0; c < 8; c++) begin
         // drive comparators from the integrator model
         if (c <= 3) begin
            pol_in = d;
            half_in = 1'b0;
         end else begin
            xj = d ? x - 4 * (c - 3) : x + 4 * (c - 3);
            if (jc != 0 && c - 3 >= jc) begin
               pol_in = (xr > 0);
               half_in = d ? (xr > -2) : (xr > 2);
            end else begin
               pol_in = (xj > 0);
               half_in = (jc == 0 && c == 7) ? (d ? (xr > -2) : (xr > 2)) : 1'b0;
            end
         end
         // first half of period c
         #0.1;
         chk(charge_o == (c <= 3), "R2 charge first half", charge_o, c <= 3);
         det = (c >= 4) && (jc != 0) && (jc + 3 < c);
         chk(discharge_o == ((c >= 4) && !det), "R3 discharge first half",
             discharge_o, (c >= 4) && !det);
         chk(sample_o == det, "R4 sample first half", sample_o, det);
         if (c == 1)
            chk(comp_pos_o == d, "R6 compensation sign", comp_pos_o, d);
         if (c != 0 && valid_o) idle_ok = 1'b0;
         @(negedge clk); #1;
         // second half of period c
         det = (jc != 0) && (jc + 3 <= c);
         chk(charge_o == (c < 3), "R2 charge second half", charge_o, c < 3);
         chk(discharge_o == ((c >= 3) && !det && c != 7), "R3 discharge second half",
             discharge_o, (c >= 3) && !det && c != 7);
         chk(sample_o == ((c >= 4) && (det || c == 7)), "R4 sample second half",
             sample_o, (c >= 4) && (det || c == 7));
         if (c == 4) begin
            chk(ref_neg_o == d, "R5 reference select", ref_neg_o, d);
            chk(thr_neg_o == d, "R5 threshold select", thr_neg_o, d);
         end
         if (c == 5)
            chk(comp_pos_o == 1'b0, "R6 compensation off", comp_pos_o, 0);
         @(posedge clk); #1;
      end
      chk(idle_ok, "R1 valid low inside conversion", !idle_ok, 0);
      chk(valid_o == 1'b1, "R1 valid at conversion end", valid_o, 1);
      chk(code_o[3:1] == exp_code[3:1], (jc == 0) ? "R9 saturated count" : "R7 sign and count",
          code_o[3:1], exp_code[3:1]);
      chk(code_o[0] == exp_code[0], "R8 extra LSB", code_o[0], exp_code[0]);
      resid = xr;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(valid_o == 1'b0, "R10 valid in reset", valid_o, 0);
      chk(code_o == 4'd0, "R10 code in reset", code_o, 0);
      chk(discharge_o == 1'b0 && sample_o == 1'b0, "R10 phases in reset",
          {discharge_o, sample_o}, 0);
      rst = 1'b0;
      for (int a = -20; a <= 20; a++) run_conv(a);
      run_conv(40);
      run_conv(-30);
      run_conv(-40);
      run_conv(30);
      run_conv(0);
      run_conv(7);
      // reset in the middle of a conversion
      repeat (3) @(posedge clk);
      #1 rst = 1'b1;
      @(posedge clk); #1;
      chk(code_o == 4'd0, "R10 code cleared", code_o, 0);
      chk(valid_o == 1'b0, "R10 valid cleared", valid_o, 0);
      rst = 1'b0;
      resid = 0;
      run_conv(9);
      run_conv(-9);
      run_conv(44);
      finish_run();
   end
endmodule